// File: doc/BRIEF.md
# PCIe Root-Port Reset Bring-Up Sequencer

This block takes a PCIe root-complex wrapper from power-on reset to link training. After a start request it holds the slot reset pin and the controller's internal reset low. It then turns on slot power and waits a programmable time, measured in clock cycles, before it lets go of the two resets in a fixed order. Next it opens a PHY-programming window. The auxiliary clock is turned on, link training is held in reset through the hold-PHY strobe, and the power-up reset is released. A separate PHY configuration engine is then started with a one-cycle pulse.

When that engine reports completion, the sequencer stops the auxiliary clock, clears the hold-PHY strobe and starts the clock again. It writes the root-complex device-type code and then raises the link-training enable. A shutdown request at any point pulls both resets low again and removes link training. Every step is one register stage apart, so the whole order can be seen cycle by cycle at the ports.

Top module: `pcieBringupSeq`

## Requirements
- R1: After `rstN` is released, every output is low, `deviceType` is 0 and `busy` is 0.
- R2: A `startReq` seen in the idle state starts a sequence. The first cycle sets every output back to its reset value, so both resets are low and power is off. `slotPowerEn` rises on the next cycle.
- R3: `ctrlResetN` rises exactly HOLD_CYCLES+1 cycles after `slotPowerEn` rises, where HOLD_CYCLES = (CLK_HZ/1000)*RESET_MS.
- R4: The controller reset is released first (`ctrlResetN` high). `slotResetN` goes high on the following cycle.
- R5: On the three cycles after that, in this order: `auxClkEn` rises, then `holdPhyRst` rises, then `powerUpRstN` rises.
- R6: `phyCfgStart` is a one-cycle pulse on the cycle after `powerUpRstN` rises. The sequencer then waits for `phyCfgDone` high for as long as it takes. `phyCfgDone` has no effect in any other state.
- R7: One cycle after the edge that samples `phyCfgDone` high, `auxClkEn` falls. On the next cycle `holdPhyRst` falls, and on the cycle after that `auxClkEn` rises again.
- R8: On the next cycle `deviceType` becomes 4 (root complex). On the cycle after that `linkTrainEn` rises.
- R9: `busy` is high from the cycle after the accepted `startReq` until `linkTrainEn` rises. `doneP` is high only on the first cycle of `linkTrainEn`.
- R10: `shutdownReq` overrides everything. After the edge that samples it, `slotResetN`, `ctrlResetN`, `linkTrainEn` and `busy` are low and the block is idle. The other outputs keep their values, and a later `startReq` starts a full sequence again.
- R11: `startReq` has no effect while a sequence is running or after link training is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start the bring-up sequence (sampled in idle) |
| shutdownReq | input | 1 | Force the resets back on and return to idle |
| phyCfgDone | input | 1 | PHY configuration engine finished |
| slotResetN | output | 1 | Slot reset pin, active low |
| ctrlResetN | output | 1 | Controller internal reset, active low |
| slotPowerEn | output | 1 | Slot power enable |
| auxClkEn | output | 1 | Auxiliary clock gate enable |
| holdPhyRst | output | 1 | Hold link training in reset during PHY programming |
| powerUpRstN | output | 1 | Controller power-up reset, active low |
| phyCfgStart | output | 1 | One-cycle start pulse to the PHY configuration engine |
| deviceType | output | TYPE_W | Device-type code, 4 selects root complex |
| linkTrainEn | output | 1 | Link training enable |
| busy | output | 1 | Sequence in progress |
| doneP | output | 1 | Pulse on the first cycle of link-training enable |

## Verification
The FSM state register decodes the strobes, and the datapath registers act on them. Each output step therefore appears one cycle after the edge that enters its state, and the step after it appears one cycle later. The bench drives inputs and samples outputs on falling edges. After each rising edge it compares the full output vector with a table row for that exact cycle, which covers R4 to R9 including a stray `phyCfgDone` and a late `startReq`. The reset hold of R3 is measured by counting falling edges from `slotPowerEn` high to `ctrlResetN` high against HOLD_CYCLES+1. Shutdown is checked on the first sample after the edge that sees it.

// File: rtl/pcieBringupPkg.sv
package pcieBringupPkg;

  typedef enum logic [4:0] {
    S_IDLE, S_ASSERT, S_POWER, S_WAIT, S_REL_CTRL, S_REL_SLOT,
    S_AUX_ON, S_HOLD_SET, S_PUR_REL, S_PHY_START, S_PHY_WAIT,
    S_AUX_OFF, S_HOLD_CLR, S_AUX_REON, S_DEV_TYPE, S_LINK_EN, S_RUN
  } seqStateT;

  typedef struct packed {
    logic shutdown;
    logic assertRst;
    logic powerOn;
    logic relCtrl;
    logic relSlot;
    logic auxOn;
    logic auxOff;
    logic holdSet;
    logic holdClr;
    logic purRel;
    logic phyStart;
    logic loadType;
    logic linkEn;
  } seqStrobeT;

endpackage

// File: rtl/pcieBringupCtrl.sv
module pcieBringupCtrl
  import pcieBringupPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      shutdownReq,
  input  logic      phyCfgDone,
  input  logic      holdDone,
  output seqStrobeT strobe,
  output logic      busy
);

  seqStateT state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    if (shutdownReq) begin
      stateNxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE:      if (startReq) stateNxt = S_ASSERT;
        S_ASSERT:    stateNxt = S_POWER;
        S_POWER:     stateNxt = S_WAIT;
        S_WAIT:      if (holdDone) stateNxt = S_REL_CTRL;
        S_REL_CTRL:  stateNxt = S_REL_SLOT;
        S_REL_SLOT:  stateNxt = S_AUX_ON;
        S_AUX_ON:    stateNxt = S_HOLD_SET;
        S_HOLD_SET:  stateNxt = S_PUR_REL;
        S_PUR_REL:   stateNxt = S_PHY_START;
        S_PHY_START: stateNxt = S_PHY_WAIT;
        S_PHY_WAIT:  if (phyCfgDone) stateNxt = S_AUX_OFF;
        S_AUX_OFF:   stateNxt = S_HOLD_CLR;
        S_HOLD_CLR:  stateNxt = S_AUX_REON;
        S_AUX_REON:  stateNxt = S_DEV_TYPE;
        S_DEV_TYPE:  stateNxt = S_LINK_EN;
        S_LINK_EN:   stateNxt = S_RUN;
        S_RUN:       stateNxt = S_RUN;
        default:     stateNxt = S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (shutdownReq) begin
      strobe.shutdown = 1'b1;
    end else begin
      case (state)
        S_ASSERT:    strobe.assertRst = 1'b1;
        S_POWER:     strobe.powerOn   = 1'b1;
        S_REL_CTRL:  strobe.relCtrl   = 1'b1;
        S_REL_SLOT:  strobe.relSlot   = 1'b1;
        S_AUX_ON:    strobe.auxOn     = 1'b1;
        S_HOLD_SET:  strobe.holdSet   = 1'b1;
        S_PUR_REL:   strobe.purRel    = 1'b1;
        S_PHY_START: strobe.phyStart  = 1'b1;
        S_AUX_OFF:   strobe.auxOff    = 1'b1;
        S_HOLD_CLR:  strobe.holdClr   = 1'b1;
        S_AUX_REON:  strobe.auxOn     = 1'b1;
        S_DEV_TYPE:  strobe.loadType  = 1'b1;
        S_LINK_EN:   strobe.linkEn    = 1'b1;
        default:     ;
      endcase
    end
  end

  assign busy = (state != S_IDLE) && (state != S_RUN);

  // R6: the PHY wait lasts until the engine reports done
  p_phy_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PHY_WAIT && !phyCfgDone && !shutdownReq) |=> (state == S_PHY_WAIT));

  // R11: a start request after link enable does not restart the sequence
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && startReq && !shutdownReq) |=> !busy);

  // R10: shutdown returns the sequencer to idle
  p_shutdown_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !busy);

endmodule

// File: rtl/pcieBringupDp.sv
module pcieBringupDp
  import pcieBringupPkg::*;
#(
  parameter int HOLD_CYCLES = 10,
  parameter int TYPE_W      = 4,
  parameter int RC_TYPE     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  output logic              holdDone,
  output logic              slotResetN,
  output logic              ctrlResetN,
  output logic              slotPowerEn,
  output logic              auxClkEn,
  output logic              holdPhyRst,
  output logic              powerUpRstN,
  output logic              phyCfgStart,
  output logic [TYPE_W-1:0] deviceType,
  output logic              linkTrainEn,
  output logic              doneP
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobe.powerOn)  holdCnt <= HOLD_LOAD;
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign holdDone = (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotResetN  <= 1'b0;
      ctrlResetN  <= 1'b0;
      slotPowerEn <= 1'b0;
      auxClkEn    <= 1'b0;
      holdPhyRst  <= 1'b0;
      powerUpRstN <= 1'b0;
      phyCfgStart <= 1'b0;
      deviceType  <= '0;
      linkTrainEn <= 1'b0;
      doneP       <= 1'b0;
    end else begin
      phyCfgStart <= strobe.phyStart;
      doneP       <= strobe.linkEn;
      if (strobe.shutdown) begin
        slotResetN  <= 1'b0;
        ctrlResetN  <= 1'b0;
        linkTrainEn <= 1'b0;
      end else if (strobe.assertRst) begin
        slotResetN  <= 1'b0;
        ctrlResetN  <= 1'b0;
        slotPowerEn <= 1'b0;
        auxClkEn    <= 1'b0;
        holdPhyRst  <= 1'b0;
        powerUpRstN <= 1'b0;
        deviceType  <= '0;
        linkTrainEn <= 1'b0;
      end else begin
        if (strobe.powerOn)  slotPowerEn <= 1'b1;
        if (strobe.relCtrl)  ctrlResetN  <= 1'b1;
        if (strobe.relSlot)  slotResetN  <= 1'b1;
        if (strobe.auxOn)    auxClkEn    <= 1'b1;
        if (strobe.auxOff)   auxClkEn    <= 1'b0;
        if (strobe.holdSet)  holdPhyRst  <= 1'b1;
        if (strobe.holdClr)  holdPhyRst  <= 1'b0;
        if (strobe.purRel)   powerUpRstN <= 1'b1;
        if (strobe.loadType) deviceType  <= TYPE_W'(RC_TYPE);
        if (strobe.linkEn)   linkTrainEn <= 1'b1;
      end
    end
  end

  // R3: the controller reset is only released with slot power on
  p_power_before_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlResetN) |-> slotPowerEn);

  // R4: controller reset leaves before the slot reset pin
  p_release_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotResetN) |-> ctrlResetN);

  // R5: power-up reset is released only inside the hold window with the clock on
  p_pur_in_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerUpRstN) |-> (holdPhyRst && auxClkEn));

  // R6: the PHY start strobe lasts one cycle
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    phyCfgStart |=> !phyCfgStart);

  // R7: hold-PHY is cleared only while the aux clock is gated
  p_hold_clear_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdPhyRst) |-> !auxClkEn);

  // R9: the done pulse coincides with link-training enable
  p_done_link_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> linkTrainEn);

  // R10: shutdown pulls both resets and link training low
  p_shutdown_resets_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shutdown |=> (!slotResetN && !ctrlResetN && !linkTrainEn));

endmodule

// File: rtl/pcieBringupSeq.sv
module pcieBringupSeq
  import pcieBringupPkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int RESET_MS = 100,
  parameter int TYPE_W   = 4,
  parameter int RC_TYPE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              shutdownReq,
  input  logic              phyCfgDone,
  output logic              slotResetN,
  output logic              ctrlResetN,
  output logic              slotPowerEn,
  output logic              auxClkEn,
  output logic              holdPhyRst,
  output logic              powerUpRstN,
  output logic              phyCfgStart,
  output logic [TYPE_W-1:0] deviceType,
  output logic              linkTrainEn,
  output logic              busy,
  output logic              doneP
);

  localparam int HOLD_CYCLES = (CLK_HZ / 1000) * RESET_MS;

  seqStrobeT strobe;
  logic      holdDone;

  pcieBringupCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .shutdownReq (shutdownReq),
    .phyCfgDone  (phyCfgDone),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .busy        (busy)
  );

  pcieBringupDp #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .TYPE_W      (TYPE_W),
    .RC_TYPE     (RC_TYPE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .holdDone    (holdDone),
    .slotResetN  (slotResetN),
    .ctrlResetN  (ctrlResetN),
    .slotPowerEn (slotPowerEn),
    .auxClkEn    (auxClkEn),
    .holdPhyRst  (holdPhyRst),
    .powerUpRstN (powerUpRstN),
    .phyCfgStart (phyCfgStart),
    .deviceType  (deviceType),
    .linkTrainEn (linkTrainEn),
    .doneP       (doneP)
  );

endmodule

// File: tb/sim_pcieBringupSeq.sv
module sim_pcieBringupSeq;

  localparam int CLK_HZ   = 20_000;
  localparam int RESET_MS = 1;
  localparam int HOLD     = (CLK_HZ / 1000) * RESET_MS;
  localparam int NROWS    = 15;

  // row: {startReq, phyCfgDone, expected vector[9:0], expected deviceType[3:0]}
  // vector: slotResetN ctrlResetN slotPowerEn auxClkEn holdPhyRst powerUpRstN phyCfgStart linkTrainEn doneP busy
  localparam logic [15:0] STEPS [NROWS] = '{
    {2'b00, 10'b1110000001, 4'd0},
    {2'b01, 10'b1111000001, 4'd0},
    {2'b00, 10'b1111100001, 4'd0},
    {2'b00, 10'b1111110001, 4'd0},
    {2'b00, 10'b1111111001, 4'd0},
    {2'b00, 10'b1111110001, 4'd0},
    {2'b00, 10'b1111110001, 4'd0},
    {2'b01, 10'b1111110001, 4'd0},
    {2'b00, 10'b1110110001, 4'd0},
    {2'b00, 10'b1110010001, 4'd0},
    {2'b00, 10'b1111010001, 4'd0},
    {2'b00, 10'b1111010001, 4'd4},
    {2'b00, 10'b1111010110, 4'd4},
    {2'b00, 10'b1111010100, 4'd4},
    {2'b10, 10'b1111010100, 4'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic shutdownReq = 1'b0;
  logic phyCfgDone = 1'b0;
  logic slotResetN, ctrlResetN, slotPowerEn, auxClkEn, holdPhyRst;
  logic powerUpRstN, phyCfgStart, linkTrainEn, busy, doneP;
  logic [3:0] deviceType;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pcieBringupSeq #(.CLK_HZ(CLK_HZ), .RESET_MS(RESET_MS)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .shutdownReq(shutdownReq),
    .phyCfgDone(phyCfgDone), .slotResetN(slotResetN), .ctrlResetN(ctrlResetN),
    .slotPowerEn(slotPowerEn), .auxClkEn(auxClkEn), .holdPhyRst(holdPhyRst),
    .powerUpRstN(powerUpRstN), .phyCfgStart(phyCfgStart), .deviceType(deviceType),
    .linkTrainEn(linkTrainEn), .busy(busy), .doneP(doneP)
  );

  function automatic logic [9:0] outVec();
    return {slotResetN, ctrlResetN, slotPowerEn, auxClkEn, holdPhyRst,
            powerUpRstN, phyCfgStart, linkTrainEn, doneP, busy};
  endfunction

  function automatic string rowReq(int k);
    if (k <= 3)  return "R5";
    if (k <= 7)  return "R6";
    if (k <= 10) return "R7";
    if (k == 11) return "R8";
    if (k <= 13) return "R9";
    return "R11";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1: reset state
    check("R1", {22'd0, outVec()}, 32'd0);
    check("R1", {28'd0, deviceType}, 32'd0);

    // R2: start, one assert cycle, then power
    startReq = 1'b1;
    step();
    startReq = 1'b0;
    check("R9", {31'd0, busy}, 32'd1);
    step();
    check("R2", {22'd0, outVec()}, 32'h001);
    step();
    check("R2", {31'd0, slotPowerEn}, 32'd1);

    // R3 and R11: hold length, with a start request inside the window
    n = 0;
    while (!ctrlResetN && n < 1000) begin
      if (n == 5) startReq = 1'b1;
      step();
      startReq = 1'b0;
      n++;
    end
    check("R3", n, HOLD + 1);
    // R4: controller reset released, slot pin still low
    check("R4", {22'd0, outVec()}, {22'd0, 10'b0110000001});

    for (int k = 0; k < NROWS; k++) begin
      startReq   = STEPS[k][15];
      phyCfgDone = STEPS[k][14];
      step();
      check(k == 0 ? "R4" : rowReq(k), {22'd0, outVec()}, {22'd0, STEPS[k][13:4]});
      check(rowReq(k), {28'd0, deviceType}, {28'd0, STEPS[k][3:0]});
    end
    startReq = 1'b0;
    phyCfgDone = 1'b0;
    step();
    check("R11", {22'd0, outVec()}, {22'd0, 10'b1111010100});

    // R10: shutdown from the running state
    shutdownReq = 1'b1;
    step();
    shutdownReq = 1'b0;
    check("R10", {22'd0, outVec()}, {22'd0, 10'b0011010000});
    check("R10", {28'd0, deviceType}, 32'd4);
    step();
    check("R10", {31'd0, busy}, 32'd0);

    // R2 restart clears everything, then R10 shutdown during the hold
    startReq = 1'b1;
    step();
    startReq = 1'b0;
    step();
    check("R2", {22'd0, outVec()}, 32'h001);
    check("R2", {28'd0, deviceType}, 32'd0);
    step();
    check("R2", {31'd0, slotPowerEn}, 32'd1);
    repeat (4) step();
    shutdownReq = 1'b1;
    step();
    shutdownReq = 1'b0;
    check("R10", {22'd0, outVec()}, {22'd0, 10'b0010000000});

    // R6: done while idle has no effect
    phyCfgDone = 1'b1;
    repeat (3) step();
    phyCfgDone = 1'b0;
    check("R6", {22'd0, outVec()}, {22'd0, 10'b0010000000});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule